// File: doc/BRIEF.md
# Timer with Shared Assignable Prescaler

This block is an up-counting timer that owns a single programmable prescaler. A control bit lends that prescaler to the timer or to a watchdog tick path. The timer counts one of two sources: a one-cycle clock enable at the instruction rate, which is one quarter of the oscillator rate, or transitions of an external pin. For the pin, the active edge is selectable.

When the prescaler belongs to the timer, it divides the timer's events by 2^(n+1). When it belongs to the watchdog, it divides incoming watchdog oscillator ticks by 2^n, and the timer then counts every selected event. When the counter rolls over, it sets a sticky interrupt flag. The interrupt output is raised only when both the local enable and the global enable are set.

Software reaches the three registers through a synchronous write port with a combinational read. The counter register has no reset, so it keeps its value across resets.

Top module: `tmr_prescaler`

## Requirements
- R1: Register map: address 0 is the counter, address 1 is control, address 2 is interrupt control (bit 0 is the overflow flag, bit 1 the local enable, bit 2 the global enable), and address 3 reads 0. After reset, control reads 0xFF, interrupt control reads 0x00, and irq is 0. The counter is not reset.
- R2: Control bit 5 selects the count source. At 0, each cycle with inst_en high is an event. At 1, transitions of ext_pin are events. The source that is not selected has no effect on the counter.
- R3: Control bit 4 selects the external edge. At 0, the count is on low-to-high transitions. At 1, the count is on high-to-low transitions. ext_pin passes through a two-flop synchronizer before edge detection.
- R4: With control bit 3 at 1, the timer advances once per selected event, undivided.
- R5: With control bit 3 at 1, wdt_tick_out pulses once per 2^n wdt_tick_in pulses, where n is control bits 2:0. With bit 3 at 0, wdt_tick_out follows wdt_tick_in undivided.
- R6: With control bit 3 at 0, the timer advances once per 2^(n+1) selected events.
- R7: A counter write loads the value, clears the prescaler, and suppresses the next two timer increments. A write that changes control bit 3 also clears the prescaler.
- R8: An increment from the all-ones value wraps the counter to 0 and sets the flag. irq is high only when the flag, the local enable and the global enable are all 1.
- R9: The flag stays set until written 0. An overflow in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_en | input | 1 | Instruction-rate count enable |
| ext_pin | input | 1 | External count pin (asynchronous) |
| wdt_tick_in | input | 1 | Watchdog oscillator tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| wdt_tick_out | output | 1 | Prescaled watchdog tick |
| irq | output | 1 | Timer interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a two-stage synchronizer. With these values, the full 1:256 timer ratio and the 1:128 watchdog ratio run end to end within a few hundred cycles. A preload near the all-ones value also brings rollover, gating and the same-cycle clear race within a handful of events.

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inst_en,
  input  logic       ext_pin,
  input  logic       wdt_tick_in,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic       wdt_tick_out,
  output logic       irq
);
  localparam int PW = 8;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [7:0]      ctl, ictl;
  logic [W-1:0]    cnt;
  logic [PW-1:0]   pcnt, mask_w, mask_t, mask;
  logic [1:0]      hold;
  logic [SYNC-1:0] sy;
  logic            pin_d;

  wire src_ext = ctl[5];
  wire fall    = ctl[4];
  wire psa     = ctl[3];
  wire pin_s   = sy[SYNC-1];

  wire ext_evt = fall ? (pin_d & ~pin_s) : (pin_s & ~pin_d);
  wire src_evt = src_ext ? ext_evt : inst_en;
  wire ps_in   = psa ? wdt_tick_in : src_evt;

  assign mask_w = (ONE << ctl[2:0]) - ONE;
  assign mask_t = {mask_w[PW-2:0], 1'b1};
  assign mask   = psa ? mask_w : mask_t;

  wire ps_hit  = ps_in && ((pcnt & mask) == mask);
  wire tmr_evt = psa ? src_evt : ps_hit;
  assign wdt_tick_out = psa ? ps_hit : wdt_tick_in;

  wire cnt_wr  = wr_en && addr == 2'd0;
  wire ctl_wr  = wr_en && addr == 2'd1;
  wire ictl_wr = wr_en && addr == 2'd2;
  wire ps_clr  = cnt_wr || (ctl_wr && wdata[3] != psa);
  wire tmr_inc = tmr_evt && hold == 2'd0 && !cnt_wr;
  wire ovf     = tmr_inc && cnt == '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy    <= '0;
      pin_d <= 1'b0;
      ctl   <= 8'hFF;
      ictl  <= 8'h00;
      pcnt  <= '0;
      hold  <= 2'd0;
    end else begin
      sy    <= {sy[SYNC-2:0], ext_pin};
      pin_d <= pin_s;
      if (ctl_wr) ctl <= wdata;
      if (ictl_wr) ictl <= {wdata[7:1], wdata[0] | ovf};
      else if (ovf) ictl[0] <= 1'b1;
      if (ps_clr) pcnt <= '0;
      else if (ps_in) pcnt <= pcnt + ONE;
      if (cnt_wr) hold <= 2'd2;
      else if (tmr_evt && hold != 2'd0) hold <= hold - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (cnt_wr) cnt <= wdata[W-1:0];
    else if (tmr_inc) cnt <= cnt + 1'b1;
  end

  assign irq = ictl[0] & ictl[1] & ictl[2];

  always_comb begin
    case (addr)
      2'd0:    rd_data = 8'(cnt);
      2'd1:    rd_data = ctl;
      2'd2:    rd_data = ictl;
      default: rd_data = 8'h00;
    endcase
  end

  assert_undivided_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psa && src_evt && hold == 2'd0 && !cnt_wr) |=> cnt == $past(cnt) + 1'b1);

  assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_evt && hold != 2'd0 && !cnt_wr) |=> $stable(cnt));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata[W-1:0]) && pcnt == '0));

  assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_inc && cnt == '1) |=> (ictl[0] && cnt == '0));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ictl[0] && !(ictl_wr && !wdata[0])) |=> ictl[0]);

  assert_wdt_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!psa && !wdt_tick_in) |-> !wdt_tick_out);
endmodule

// File: tb/tmr_prescaler_bench.sv
module tmr_prescaler_bench;
  logic clk = 0, rst_n = 0, inst_en = 0, ext_pin = 0, wdt_tick_in = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rd_data;
  logic wdt_tick_out, irq;

  always #10 clk = ~clk;

  tmr_prescaler u_tmr_prescaler (
    .clk(clk), .rst_n(rst_n), .inst_en(inst_en), .ext_pin(ext_pin),
    .wdt_tick_in(wdt_tick_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .wdt_tick_out(wdt_tick_out), .irq(irq));

  typedef struct { int kind; int val; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, wdt_seen = 0;
  logic chk_v = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (wdt_tick_out) wdt_seen++;
    if (chk_v && q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(rd_data);
        1: act = int'(irq);
        default: begin act = wdt_seen; wdt_seen = 0; end
      endcase
      checks++;
      if (act != it.val) begin
        fails++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_item(int kind, int a, int v, string tag);
    item_t it;
    it.kind = kind; it.val = v; it.tag = tag;
    addr = 2'(a);
    q.push_back(it);
    chk_v = 1;
    step();
    chk_v = 0;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = 2'(a); wdata = 8'(d);
    step();
    wr_en = 0;
  endtask

  task automatic inst(int n);
    inst_en = 1; step(n); inst_en = 0; step(2);
  endtask

  task automatic wticks(int n);
    repeat (n) begin wdt_tick_in = 1; step(); wdt_tick_in = 0; step(); end
  endtask

  task automatic pin_pulses(int n);
    repeat (n) begin ext_pin = 1; step(3); ext_pin = 0; step(3); end
    step(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    @(posedge clk); #1 rst_n = 1;
    step();
    expect_item(0, 1, 8'hFF, "R1 control reset");
    expect_item(0, 2, 8'h00, "R1 intctl reset");
    expect_item(0, 3, 8'h00, "R1 unused address");
    expect_item(1, 0, 0, "R1 irq reset");

    wticks(256);
    expect_item(2, 0, 2, "R5 wdt 1:128 at reset");

    wr(1, 8'h08);
    wticks(5);
    expect_item(2, 0, 5, "R5 wdt 1:1");
    wr(0, 8'h10);
    inst(5);
    expect_item(0, 0, 8'h13, "R4 R7 undivided with holdoff");
    pin_pulses(3);
    expect_item(0, 0, 8'h13, "R2 pin ignored on internal source");

    wr(1, 8'h01);
    wr(0, 8'h00);
    inst(20);
    expect_item(0, 0, 8'h03, "R6 timer 1:4");
    wticks(3);
    expect_item(2, 0, 3, "R5 wdt passthrough");

    wr(1, 8'h07);
    wr(0, 8'h00);
    inst(767);
    expect_item(0, 0, 8'h00, "R6 timer 1:256 before edge");
    inst(1);
    expect_item(0, 0, 8'h01, "R6 timer 1:256 at edge");

    wr(1, 8'h01);
    wr(0, 8'h00);
    inst(8);
    inst(3);
    wr(1, 8'h09);
    wr(1, 8'h01);
    inst(3);
    expect_item(0, 0, 8'h00, "R7 prescaler cleared by assignment");
    inst(1);
    expect_item(0, 0, 8'h01, "R7 prescaler count after clear");

    wr(1, 8'h28);
    wr(0, 8'h05);
    pin_pulses(4);
    expect_item(0, 0, 8'h07, "R3 rising edges");
    inst(10);
    expect_item(0, 0, 8'h07, "R2 inst_en ignored on pin source");

    wr(1, 8'h38);
    wr(0, 8'h00);
    pin_pulses(4);
    expect_item(0, 0, 8'h02, "R3 falling edges");

    wr(1, 8'h08);
    wr(2, 8'h06);
    wr(0, 8'hFD);
    inst(4);
    expect_item(0, 0, 8'hFF, "R8 before rollover");
    expect_item(1, 0, 0, "R8 no irq before rollover");
    inst(1);
    expect_item(0, 0, 8'h00, "R8 wrap to zero");
    expect_item(0, 2, 8'h07, "R8 flag set");
    expect_item(1, 0, 1, "R8 irq raised");
    wr(2, 8'h06);
    expect_item(1, 0, 0, "R9 flag cleared by write");

    wr(2, 8'h02);
    wr(0, 8'hFF);
    inst(3);
    expect_item(0, 2, 8'h03, "R8 flag with global off");
    expect_item(1, 0, 0, "R8 irq gated by global enable");
    wr(2, 8'h05);
    expect_item(1, 0, 0, "R8 irq gated by local enable");

    wr(2, 8'h00);
    wr(0, 8'hFF);
    inst(2);
    wr_en = 1; addr = 2'd2; wdata = 8'h00; inst_en = 1;
    step();
    wr_en = 0; inst_en = 0;
    expect_item(0, 2, 8'h01, "R9 overflow beats clear");
    expect_item(0, 0, 8'h00, "R9 counter wrapped");

    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule